// File: doc/BRIEF.md
# Status Flags and Interrupt Pin Controller

This block collects single-cycle event pulses from an image capture pipeline into a byte-wide register of sticky flags. Software reads the flags through a readback port and clears them by writing ones to their positions. A second byte-wide register holds one global interrupt enable and one enable per event source. Together they decide whether an interrupt is pending.

The block drives a single active-low pin that serves one of two functions. In interrupt mode the pin carries the registered interrupt request. A pull-up disable input then chooses between a push-pull high and an undriven, open-drain style high while the request is inactive. In capture-complete mode the pin reports capture progress instead. It is either a 4-clock low pulse after each capture-done event, or a low level that follows the run input for as long as the capture runs.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset the status readback is 0 when the run input is low, the mask readback is 0x00, and in interrupt mode with the pull-up enabled the pin is driven high (pin_o = 1, pin_oe_o = 1).
- R2: Status readback layout: bit 0 shows run_i live, bits 1..6 are the flags for ev_i[0..5] (row done, frame done, capture done, exposure shadow sampled, sample shadow sampled, shutter sync), and bit 7 always reads 0.
- R3: A one-cycle pulse on ev_i[k] sets status bit k+1, and the bit is visible on the readback after the clock edge that samples the pulse.
- R4: A flag stays set until a status write has a 1 in its bit position. A 0 in a position leaves that flag unchanged, and ones in bits 0 and 7 have no effect.
- R5: When an event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R6: A mask write stores bits 0..6 (bit 0 global enable, bits 1..6 the source enables in status order). Bit 7 always reads back as 0.
- R7: The interrupt request is registered. It becomes active on the clock edge after the global enable is 1 and some flag is set together with its mask bit, and it drops on the edge after that condition ends.
- R8: During the cycle in which a clearing write is presented, the readback still shows the flag as set. It reads 0 after the edge.
- R9: In interrupt mode (cc_sel_i = 0) an active request drives the pin low with pin_oe_o = 1. An inactive request drives it high when pull_dis_i = 0, and releases it (pin_oe_o = 0) when pull_dis_i = 1.
- R10: In capture-complete mode (cc_sel_i = 1, cc_level_i = 0) a capture-done event (ev_i[2]) pulls the pin low for exactly 4 clocks, starting at the edge that samples the event. The pin is always driven in this mode, and the interrupt request does not reach it.
- R11: In capture-complete mode with cc_level_i = 1 the pin goes low on the edge after run_i rises and stays low until the edge after run_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 6 | Event pulses: [0] row done, [1] frame done, [2] capture done, [3] exposure shadow sampled, [4] sample shadow sampled, [5] shutter sync |
| run_i | input | 1 | Run level, shown as status bit 0 |
| stat_wr_i | input | 1 | Write strobe for the status register (write-one-to-clear) |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| wdata_i | input | 8 | Write data shared by both registers |
| cc_sel_i | input | 1 | Pin function: 1 capture complete, 0 interrupt request |
| pull_dis_i | input | 1 | Interrupt mode: 1 leaves the inactive pin undriven |
| cc_level_i | input | 1 | Capture complete: 1 level over the run, 0 4-clock pulse |
| stat_rd_o | output | 8 | Status readback |
| mask_rd_o | output | 8 | Mask readback |
| pin_o | output | 1 | Active-low pin value |
| pin_oe_o | output | 1 | Pin drive enable |

## Verification
An event pulse and a software clear of the same flag can land in the same clock cycle, and the same is true of a clear and a readback of that flag. The bench drives an event and a clearing write on one cycle and expects the flag to survive. It also drives a clear and samples the readback just after the inputs change, before the edge, to confirm the pre-clear value. The capture-done event can also set its flag and start the capture-complete pulse at once. With its interrupt enabled, the bench checks that the pin shows only the pulse.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 6;
  // positions 1..NUM_SRC hold sticky event flags
  localparam logic [REG_W-1:0] SRC_BITS  = 8'b0111_1110;
  localparam logic [REG_W-1:0] MASK_BITS = 8'b0111_1111;

  // place the event vector on its status positions
  function automatic logic [REG_W-1:0] ev_to_pos(input logic [NUM_SRC-1:0] ev);
    return {1'b0, ev, 1'b0};
  endfunction

  // pending request: global enable and any enabled set flag
  function automatic logic irq_pending(input logic [REG_W-1:0] mask,
                                       input logic [REG_W-1:0] flags);
    return mask[0] & (|(mask & flags & SRC_BITS));
  endfunction
endpackage

// File: rtl/stat_flag_bank.sv
module stat_flag_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] STICKY = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (STICKY[g]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o[g] <= 1'b0;
        else        q_o[g] <= set_i[g] | (q_o[g] & ~clr_i[g]);
      end
    end else begin : g_none
      assign q_o[g] = 1'b0;
    end
  end

  // R4: a set flag only falls when it was cleared
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));
  // R3 / R5: an event always leaves its flag set
  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_i) & STICKY & ~q_o) == '0));
endmodule

// File: rtl/stat_irq_eval.sv
module stat_irq_eval
  import stat_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] flags_i,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  logic [REG_W-1:0] mask_q;
  logic             irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= wdata_i & MASK_BITS;
      irq_q <= irq_pending(mask_q, flags_i);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R7: no request without the global enable one cycle earlier
  assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[0] |=> !irq_q);
  // R7: a request needs some flag set in the previous cycle
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|flags_i));
endmodule

// File: rtl/stat_cc_gen.sv
module stat_cc_gen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  logic run_i,
  input  logic level_i,
  output logic cc_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             pulse_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (cap_i)              cnt_q <= CNT_W'(PULSE_LEN);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_act = (cnt_q != '0);
  assign cc_o      = level_i ? run_q : pulse_act;

  // R10: a pulse only starts from a capture-done event
  assert_pulse_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_act) |-> $past(cap_i));
  // R11: the level copy follows run one cycle late
  assert_level_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(run_i));
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               run_i,
  input  logic               stat_wr_i,
  input  logic               mask_wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               cc_sel_i,
  input  logic               pull_dis_i,
  input  logic               cc_level_i,
  output logic [REG_W-1:0]   stat_rd_o,
  output logic [REG_W-1:0]   mask_rd_o,
  output logic               pin_o,
  output logic               pin_oe_o
);
  logic [REG_W-1:0] ev_pos;
  logic [REG_W-1:0] clr_pos;
  logic [REG_W-1:0] flags;
  logic             irq_act;
  logic             cc_act;

  assign ev_pos  = ev_to_pos(ev_i);
  assign clr_pos = {REG_W{stat_wr_i}} & wdata_i;

  stat_flag_bank #(.W(REG_W), .STICKY(SRC_BITS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_pos),
    .clr_i (clr_pos),
    .q_o   (flags)
  );

  stat_irq_eval u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr_i (mask_wr_i),
    .wdata_i   (wdata_i),
    .flags_i   (flags),
    .mask_o    (mask_rd_o),
    .irq_o     (irq_act)
  );

  stat_cc_gen #(.PULSE_LEN(PULSE_LEN)) u_cc (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (ev_i[2]),
    .run_i   (run_i),
    .level_i (cc_level_i),
    .cc_o    (cc_act)
  );

  assign stat_rd_o = flags | {{(REG_W-1){1'b0}}, run_i};

  always_comb begin
    if (cc_sel_i) begin
      pin_o    = ~cc_act;
      pin_oe_o = 1'b1;
    end else begin
      pin_o    = ~irq_act;
      pin_oe_o = irq_act | ~pull_dis_i;
    end
  end

  // R9: a low pin is always actively driven
  assert_low_is_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_o |-> pin_oe_o);
  // R2: reserved status position never reads 1
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_o[REG_W-1]);
endmodule

// File: tb/tb_stat_irq_ctrl.sv
module tb_stat_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ev_i = '0;
  logic       run_i = 1'b0;
  logic       stat_wr_i = 1'b0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       cc_sel_i = 1'b0;
  logic       pull_dis_i = 1'b0;
  logic       cc_level_i = 1'b0;
  logic [7:0] stat_rd_o, mask_rd_o;
  logic       pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stat_irq_ctrl dut (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ev(input int k);
    ev_i = 6'(1 << k);
    step(1);
    ev_i = '0;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    stat_wr_i = 1'b1; wdata_i = d;
    step(1);
    stat_wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic wr_mask(input logic [7:0] d);
    mask_wr_i = 1'b1; wdata_i = d;
    step(1);
    mask_wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 status", stat_rd_o, 8'h00);
    chk("R1 mask", mask_rd_o, 8'h00);
    chk("R1 pin", {pin_o, pin_oe_o}, 8'h03);
  endtask

  task automatic t_layout;
    run_i = 1'b1; #1;
    chk("R2 run bit", stat_rd_o, 8'h01);
    step(1); run_i = 1'b0; #1;
    chk("R2 run low", stat_rd_o, 8'h00);
    wr_mask(8'hFF);
    chk("R6 mask reserved", mask_rd_o, 8'h7F);
    wr_mask(8'h00);
    for (int k = 0; k < 6; k++) begin
      pulse_ev(k);
      chk($sformatf("R3 event %0d", k), stat_rd_o, 8'(1 << (k + 1)));
      wr_stat(8'hFF);
      chk("R4 clear all", stat_rd_o, 8'h00);
    end
  endtask

  task automatic t_sticky;
    ev_i = 6'b000011; step(1); ev_i = '0;
    step(3);
    chk("R4 held", stat_rd_o, 8'h06);
    wr_stat(8'h02);
    chk("R4 selective clear", stat_rd_o, 8'h04);
    wr_stat(8'h81);
    chk("R4 run/reserved write", stat_rd_o, 8'h04);
    wr_stat(8'h04);
    chk("R4 cleared", stat_rd_o, 8'h00);
  endtask

  task automatic t_collision;
    ev_i = 6'b000001; stat_wr_i = 1'b1; wdata_i = 8'h02;
    step(1);
    ev_i = '0; stat_wr_i = 1'b0; wdata_i = '0;
    chk("R5 set wins from clear", stat_rd_o, 8'h02);
    ev_i = 6'b000001; stat_wr_i = 1'b1; wdata_i = 8'h02;
    step(1);
    ev_i = '0; stat_wr_i = 1'b0; wdata_i = '0;
    chk("R5 set wins from set", stat_rd_o, 8'h02);
    wr_stat(8'h02);
  endtask

  task automatic t_readback;
    pulse_ev(2);
    stat_wr_i = 1'b1; wdata_i = 8'h08; #1;
    chk("R8 pre-clear view", stat_rd_o, 8'h08);
    step(1);
    stat_wr_i = 1'b0; wdata_i = '0;
    chk("R8 after clear", stat_rd_o, 8'h00);
  endtask

  task automatic t_irq;
    wr_mask(8'h02);
    pulse_ev(0);
    step(2);
    chk("R7 no global", {7'b0, pin_o}, 8'h01);
    wr_mask(8'h03);
    chk("R7 registered delay", {7'b0, pin_o}, 8'h01);
    step(1);
    chk("R7 asserted", {7'b0, pin_o}, 8'h00);
    wr_stat(8'h02);
    chk("R7 held one cycle", {7'b0, pin_o}, 8'h00);
    step(1);
    chk("R7 released", {7'b0, pin_o}, 8'h01);
    pulse_ev(1);
    step(2);
    chk("R7 source masked", {7'b0, pin_o}, 8'h01);
    wr_stat(8'h04);
    wr_mask(8'h00);
  endtask

  task automatic t_drive;
    step(1);
    chk("R9 pull-up high", {pin_o, pin_oe_o}, 8'h03);
    pull_dis_i = 1'b1; #1;
    chk("R9 released", {7'b0, pin_oe_o}, 8'h00);
    wr_mask(8'h03);
    pulse_ev(0);
    step(1);
    chk("R9 active drive", {pin_o, pin_oe_o}, 8'h01);
    wr_stat(8'h02);
    wr_mask(8'h00);
    step(2);
    chk("R9 open-drain idle", {7'b0, pin_oe_o}, 8'h00);
    pull_dis_i = 1'b0;
  endtask

  task automatic t_cc_pulse;
    cc_sel_i = 1'b1; cc_level_i = 1'b0;
    wr_mask(8'h09);
    step(1);
    chk("R10 idle", {pin_o, pin_oe_o}, 8'h03);
    pulse_ev(2);
    for (int i = 1; i <= 4; i++) begin
      chk($sformatf("R10 pulse clock %0d", i), {pin_o, pin_oe_o}, 8'h01);
      step(1);
    end
    chk("R10 pulse end, irq hidden", {pin_o, pin_oe_o}, 8'h03);
    wr_stat(8'h08);
    wr_mask(8'h00);
  endtask

  task automatic t_cc_level;
    cc_level_i = 1'b1;
    run_i = 1'b1; #1;
    chk("R11 not before edge", {7'b0, pin_o}, 8'h01);
    step(1);
    chk("R11 low", {7'b0, pin_o}, 8'h00);
    step(5);
    chk("R11 held", {7'b0, pin_o}, 8'h00);
    run_i = 1'b0;
    step(1);
    chk("R11 end", {7'b0, pin_o}, 8'h01);
    cc_sel_i = 1'b0; cc_level_i = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_layout();
    t_sticky();
    t_collision();
    t_readback();
    t_irq();
    t_drive();
    t_cc_pulse();
    t_cc_level();
    step(2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule